// File: doc/BRIEF.md
# SDRAM Cache-Line Burst Read Sequencer

This block fills one 16-byte cache line from a synchronous DRAM. A fill request carries the word address of the missed word. The sequencer then issues the whole bus sequence on its own pins:

- one row activate cycle;
- a run-time selected number of wait cycles before the first column command;
- one column read command per beat, each with its own column address;
- capture of each returned word after the configured CAS latency;
- a run-time selected number of precharge cycles.

The missed word is always fetched first. The other words of the aligned 16-byte line follow in wraparound order. A bus-start strobe marks every cycle in which a data word is on the bus.

The data bus is 32 bits wide by default, which gives four beats per line. Setting `DATA_W` to 16 gives eight beats per line. The request address is a word address, equal to the byte address shifted right by log2(DATA_W/8). Its low `COL_W` bits form the column and the next `SD_A_W` bits form the row. Each beat is handed back to the cache with its word index. A done pulse closes the fill. A new request is taken only while the sequencer is idle.

Top module: `sdram_line_fill`

## Requirements
- R1: A fill returns NB = 16/(DATA_W/8) beats on `beat_valid_o`, with NB = 4 by default. Beat k carries the index (s + k) mod NB on `beat_idx_o`, where s is the low log2(NB) bits of `req_addr_i`.
- R2: After acceptance the pins show one activate cycle (`sd_ras_n_o` low), then exactly `cfg_rcd_i` wait cycles, then NB consecutive column-read cycles (`sd_cas_n_o` low). RAS and CAS are never low in the same cycle.
- R3: In the activate cycle, `sd_addr_o` carries the row (`req_addr_i[COL_W +: SD_A_W]`). In column cycle k, bits [COL_W-1:0] hold the request column with its low log2(NB) bits replaced by the wrapped index of beat k. Bit `CMD_BIT` (default 10) is 1 on the last column command only, which requests auto-precharge. All other address bits are 0.
- R4: The word read by column command k is sampled from `sd_dq_i` at the end of the cycle that lies CL cycles after that command. It appears on `beat_data_o` in the next cycle. CL is `cfg_cas_lat_i`, and a value of 0 acts as 1.
- R5: `sd_cs_n_o` is low from the activate cycle through the last data cycle and high at all other times. `sd_we_n_o` is always 1 (read) and `sd_dqm_o` is always 0.
- R6: `sd_bs_n_o` is low in exactly the NB data cycles of a fill.
- R7: After the last data cycle come `cfg_rp_i` precharge cycles with chip select high. `done_o` then pulses for one cycle in the following cycle. With `cfg_rp_i` = 0, `done_o` coincides with the last beat.
- R8: `req_ready_o` is high exactly while the sequencer is idle, including the done cycle. Configuration is sampled at acceptance. A request raised while busy, and any change to the configuration during a fill, have no effect on that fill.
- R9: After reset `req_ready_o` is 1, all bus strobes are high, and neither `beat_valid_o` nor `done_o` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fill request |
| req_addr_i | input | COL_W+SD_A_W | Word address of missed word |
| cfg_cas_lat_i | input | 2 | CAS latency, 1 to 3 (0 acts as 1) |
| cfg_rcd_i | input | 2 | Wait cycles between activate and first column |
| cfg_rp_i | input | 2 | Precharge cycles after the last data cycle |
| req_ready_o | output | 1 | Idle, request may be taken |
| beat_valid_o | output | 1 | Beat data valid |
| beat_idx_o | output | log2(NB) | Word index of the beat within the line |
| beat_data_o | output | DATA_W | Beat data |
| done_o | output | 1 | Fill complete pulse |
| sd_cs_n_o | output | 1 | Chip select |
| sd_ras_n_o | output | 1 | Row strobe |
| sd_cas_n_o | output | 1 | Column strobe |
| sd_we_n_o | output | 1 | Read/write line, held at read |
| sd_dqm_o | output | DATA_W/8 | Byte masks, held enabled |
| sd_addr_o | output | SD_A_W | Multiplexed DRAM address |
| sd_bs_n_o | output | 1 | Bus-start strobe |
| sd_dq_i | input | DATA_W | DRAM read data |

## Verification
With the CAS latency below NB, column commands and data cycles overlap. The bench therefore compares the CAS strobe, the column address and the bus-start strobe in the same cycles across latencies 1, 2 and 3. With a zero precharge count, the last beat and the done pulse fall in one cycle. The bench provokes this case and then issues the next request in that same cycle, so it also sees the fill restart at once. The bench model also drives the DRAM data from the addresses it observes, so a wrong column or a wrong capture cycle shows up as a data mismatch.

// File: rtl/sdram_fill_pkg.sv
package sdram_fill_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ACT,
    PH_RCD,
    PH_RUN,
    PH_PRE
  } phase_e;
endpackage

// File: rtl/sdram_fill_seq.sv
module sdram_fill_seq
  import sdram_fill_pkg::*;
#(
  parameter int NB    = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       cfg_cas_lat_i,
  input  logic [1:0]       cfg_rcd_i,
  input  logic [1:0]       cfg_rp_i,
  output logic             accept_o,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       cl_o,
  output logic             done_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       cl_q, rcd_q, rp_q;
  logic             done_q;
  logic [CNT_W-1:0] run_last;

  assign accept_o = (phase_q == PH_IDLE) && req_valid_i;
  assign run_last = CNT_W'(NB - 1) + CNT_W'(cl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cl_q    <= 2'd1;
      rcd_q   <= '0;
      rp_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid_i) begin
            cl_q    <= (cfg_cas_lat_i == 2'd0) ? 2'd1 : cfg_cas_lat_i;
            rcd_q   <= cfg_rcd_i;
            rp_q    <= cfg_rp_i;
            cnt_q   <= '0;
            phase_q <= PH_ACT;
          end
        end
        PH_ACT: begin
          cnt_q   <= '0;
          phase_q <= (rcd_q == 2'd0) ? PH_RUN : PH_RCD;
        end
        PH_RCD: begin
          if (cnt_q == CNT_W'(rcd_q) - CNT_W'(1)) begin
            cnt_q   <= '0;
            phase_q <= PH_RUN;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RUN: begin
          if (cnt_q == run_last) begin
            cnt_q <= '0;
            if (rp_q == 2'd0) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_PRE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_PRE: begin
          if (cnt_q == CNT_W'(rp_q) - CNT_W'(1)) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign cl_o    = cl_q;
  assign done_o  = done_q;
endmodule

// File: rtl/sdram_fill_addr.sv
module sdram_fill_addr
  import sdram_fill_pkg::*;
#(
  parameter int SD_A_W  = 13,
  parameter int COL_W   = 9,
  parameter int CMD_BIT = 10,
  parameter int NB      = 4,
  parameter int IDX_W   = 2,
  parameter int CNT_W   = 3,
  localparam int AW     = COL_W + SD_A_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [AW-1:0]     req_addr_i,
  input  phase_e            phase_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              col_cmd_o,
  output logic [IDX_W-1:0]  start_idx_o,
  output logic [SD_A_W-1:0] sd_addr_o
);
  logic [AW-1:0]    addr_q;
  logic [IDX_W-1:0] col_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (accept_i) addr_q <= req_addr_i;
  end

  assign start_idx_o = addr_q[IDX_W-1:0];
  assign col_cmd_o   = (phase_i == PH_RUN) && (cnt_i < CNT_W'(NB));
  assign col_idx     = addr_q[IDX_W-1:0] + cnt_i[IDX_W-1:0];

  always_comb begin
    sd_addr_o = '0;
    if (phase_i == PH_ACT) begin
      sd_addr_o = addr_q[AW-1:COL_W];
    end else if (col_cmd_o) begin
      sd_addr_o[COL_W-1:0] = {addr_q[COL_W-1:IDX_W], col_idx};
      // auto-precharge request rides on the final column command
      sd_addr_o[CMD_BIT]   = (cnt_i == CNT_W'(NB - 1));
    end
  end
endmodule

// File: rtl/sdram_fill_capture.sv
module sdram_fill_capture
  import sdram_fill_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        cl_i,
  input  logic [IDX_W-1:0]  start_idx_i,
  input  logic [DATA_W-1:0] sd_dq_i,
  output logic              data_cyc_o,
  output logic              beat_valid_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic [DATA_W-1:0] beat_data_o
);
  logic              vld_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] dat_q;

  assign data_cyc_o = (phase_i == PH_RUN) && (cnt_i >= CNT_W'(cl_i))
                   && (cnt_i < CNT_W'(cl_i) + CNT_W'(NB));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q <= data_cyc_o;
      if (data_cyc_o) begin
        dat_q <= sd_dq_i;
        idx_q <= start_idx_i + IDX_W'(cnt_i) - IDX_W'(cl_i);
      end
    end
  end

  assign beat_valid_o = vld_q;
  assign beat_idx_o   = idx_q;
  assign beat_data_o  = dat_q;
endmodule

// File: rtl/sdram_line_fill.sv
module sdram_line_fill
  import sdram_fill_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COL_W   = 9,
  parameter int SD_A_W  = 13,
  parameter int CMD_BIT = 10,
  localparam int BYTES  = DATA_W / 8,
  localparam int NB     = 16 / BYTES,
  localparam int IDX_W  = $clog2(NB),
  localparam int CNT_W  = $clog2(NB + 4),
  localparam int AW     = COL_W + SD_A_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [1:0]        cfg_cas_lat_i,
  input  logic [1:0]        cfg_rcd_i,
  input  logic [1:0]        cfg_rp_i,
  output logic              req_ready_o,
  output logic              beat_valid_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic [DATA_W-1:0] beat_data_o,
  output logic              done_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BYTES-1:0]  sd_dqm_o,
  output logic [SD_A_W-1:0] sd_addr_o,
  output logic              sd_bs_n_o,
  input  logic [DATA_W-1:0] sd_dq_i
);
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       cl;
  logic             accept, col_cmd, data_cyc;
  logic [IDX_W-1:0] start_idx;

  sdram_fill_seq #(.NB(NB), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .cfg_cas_lat_i, .cfg_rcd_i, .cfg_rp_i,
    .accept_o(accept), .phase_o(phase), .cnt_o(cnt), .cl_o(cl), .done_o
  );

  sdram_fill_addr #(
    .SD_A_W(SD_A_W), .COL_W(COL_W), .CMD_BIT(CMD_BIT),
    .NB(NB), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_addr (
    .clk_i, .rst_ni, .accept_i(accept), .req_addr_i,
    .phase_i(phase), .cnt_i(cnt),
    .col_cmd_o(col_cmd), .start_idx_o(start_idx), .sd_addr_o
  );

  sdram_fill_capture #(
    .DATA_W(DATA_W), .NB(NB), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_cap (
    .clk_i, .rst_ni, .phase_i(phase), .cnt_i(cnt), .cl_i(cl),
    .start_idx_i(start_idx), .sd_dq_i,
    .data_cyc_o(data_cyc), .beat_valid_o, .beat_idx_o, .beat_data_o
  );

  assign req_ready_o = (phase == PH_IDLE);
  assign sd_cs_n_o   = !(phase inside {PH_ACT, PH_RCD, PH_RUN});
  assign sd_ras_n_o  = (phase != PH_ACT);
  assign sd_cas_n_o  = !col_cmd;
  assign sd_we_n_o   = 1'b1;
  assign sd_dqm_o    = '0;
  assign sd_bs_n_o   = !data_cyc;
endmodule

// File: rtl/sdram_line_fill_chk.sv
module sdram_line_fill_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              beat_valid_o,
  input logic [IDX_W-1:0]  beat_idx_o,
  input logic              done_o,
  input logic              sd_cs_n_o,
  input logic              sd_ras_n_o,
  input logic              sd_cas_n_o,
  input logic              sd_we_n_o,
  input logic [DATA_W/8-1:0] sd_dqm_o,
  input logic              sd_bs_n_o
);
  AST_RAS_CAS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!sd_ras_n_o && !sd_cas_n_o)); // R2
  AST_ACT_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !sd_ras_n_o); // R2
  AST_BS_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sd_bs_n_o |-> !sd_cs_n_o); // R6
  AST_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_we_n_o && (sd_dqm_o == '0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sd_cs_n_o && sd_ras_n_o && sd_cas_n_o && sd_bs_n_o)); // R9
  AST_BEAT_WRAP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && $past(beat_valid_o)) |-> beat_idx_o == $past(beat_idx_o) + 1'b1); // R1
endmodule

bind sdram_line_fill sdram_line_fill_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .beat_valid_o(beat_valid_o), .beat_idx_o(beat_idx_o), .done_o(done_o),
  .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
  .sd_we_n_o(sd_we_n_o), .sd_dqm_o(sd_dqm_o), .sd_bs_n_o(sd_bs_n_o)
);

// File: tb/sdram_line_fill_tb.sv
module sdram_line_fill_tb;
  localparam int DATA_W = 32, COL_W = 9, SD_A_W = 13, CMD_BIT = 10;
  localparam int NB = 4, IDX_W = 2, AW = COL_W + SD_A_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] cfg_cl = 2'd2, cfg_rcd = 2'd1, cfg_rp = 2'd1;
  logic ready, bv, done, cs_n, ras_n, cas_n, we_n, bs_n;
  logic [IDX_W-1:0] bidx;
  logic [DATA_W-1:0] bdata, dq = '0;
  logic [3:0] dqm;
  logic [SD_A_W-1:0] sa;

  always #4 clk = ~clk;

  sdram_line_fill u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .cfg_cas_lat_i(cfg_cl), .cfg_rcd_i(cfg_rcd), .cfg_rp_i(cfg_rp),
    .req_ready_o(ready), .beat_valid_o(bv), .beat_idx_o(bidx), .beat_data_o(bdata),
    .done_o(done), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n),
    .sd_we_n_o(we_n), .sd_dqm_o(dqm), .sd_addr_o(sa), .sd_bs_n_o(bs_n), .sd_dq_i(dq)
  );

  typedef struct {
    bit cs_n, ras_n, cas_n, bs_n, ready, bv, done, chk_addr;
    logic [SD_A_W-1:0] addr;
    int idx;
    logic [DATA_W-1:0] data;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, burst_cl = 1;
  bit finished = 0;
  logic [DATA_W-1:0] pipe [4];
  logic [SD_A_W-1:0] row_lat = '0;

  function automatic logic [DATA_W-1:0] word_of(int row, int col);
    return (DATA_W'(row) * 32'h0000_9E37) ^ (DATA_W'(col) * 32'h0101_0011) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic exp_t idle_e();
    exp_t e;
    e.cs_n = 1; e.ras_n = 1; e.cas_n = 1; e.bs_n = 1; e.ready = 1;
    e.bv = 0; e.done = 0; e.chk_addr = 0; e.addr = '0; e.idx = 0; e.data = '0;
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  // expected pin/beat schedule for one fill, starting the cycle after acceptance
  task automatic plan(logic [AW-1:0] a, int cl_in, int rcd, int rp);
    int cl = (cl_in == 0) ? 1 : cl_in;
    int row = int'(a[AW-1:COL_W]);
    int st = int'(a[IDX_W-1:0]);
    int base = int'(a[COL_W-1:0]) & ~(NB - 1);
    exp_t e;
    e = idle_e(); e.ready = 0; e.cs_n = 0; e.ras_n = 0; e.chk_addr = 1;
    e.addr = SD_A_W'(row); q.push_back(e);
    for (int i = 0; i < rcd; i++) begin
      e = idle_e(); e.ready = 0; e.cs_n = 0; q.push_back(e);
    end
    for (int r = 0; r <= NB - 1 + cl; r++) begin
      e = idle_e(); e.ready = 0; e.cs_n = 0;
      if (r < NB) begin
        e.cas_n = 0; e.chk_addr = 1;
        e.addr = SD_A_W'(base + ((st + r) % NB));
        if (r == NB - 1) e.addr[CMD_BIT] = 1'b1;
      end
      if (r >= cl) e.bs_n = 0;
      if (r >= cl + 1) begin
        e.bv = 1; e.idx = (st + r - cl - 1) % NB;
        e.data = word_of(row, base + e.idx);
      end
      q.push_back(e);
    end
    for (int p = 0; p < rp; p++) begin
      e = idle_e(); e.ready = 0;
      if (p == 0) begin
        e.bv = 1; e.idx = (st + NB - 1) % NB; e.data = word_of(row, base + e.idx);
      end
      q.push_back(e);
    end
    e = idle_e(); e.done = 1;
    if (rp == 0) begin
      e.bv = 1; e.idx = (st + NB - 1) % NB; e.data = word_of(row, base + e.idx);
    end
    q.push_back(e);
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    cyc++;
    e = (q.size() != 0) ? q.pop_front() : idle_e();
    chk("R5 cs_n", 64'(cs_n), 64'(e.cs_n));
    chk("R2 ras_n", 64'(ras_n), 64'(e.ras_n));
    chk("R2 cas_n", 64'(cas_n), 64'(e.cas_n));
    chk("R6 bs_n", 64'(bs_n), 64'(e.bs_n));
    chk("R8 ready", 64'(ready), 64'(e.ready));
    chk("R1 beat_valid", 64'(bv), 64'(e.bv));
    chk("R7 done", 64'(done), 64'(e.done));
    chk("R5 we_n/dqm", 64'({we_n, dqm}), 64'({1'b1, 4'h0}));
    if (e.chk_addr) chk("R3 addr", 64'(sa), 64'(e.addr));
    if (e.bv) begin
      chk("R1 beat_idx", 64'(bidx), 64'(e.idx));
      chk("R4 beat_data", 64'(bdata), 64'(e.data));
    end
    // behavioural DRAM: answers each column command burst_cl cycles later
    if (!ras_n) row_lat = sa;
    if (!cas_n) pipe[burst_cl] = word_of(int'(row_lat), int'(sa[COL_W-1:0]));
    dq = pipe[0];
    for (int i = 0; i < 3; i++) pipe[i] = pipe[i + 1];
    pipe[3] = 32'hBAD0_BAD0;
  endtask

  task automatic fill(logic [AW-1:0] a, int cl, int rcd, int rp, bit noise);
    req_valid = 1; req_addr = a;
    cfg_cl = 2'(cl); cfg_rcd = 2'(rcd); cfg_rp = 2'(rp);
    burst_cl = (cl == 0) ? 1 : cl;
    plan(a, cl, rcd, rp);
    step();
    req_valid = 0;
    while (q.size() != 0) begin
      if (noise) begin  // R8: busy requests and config changes must be ignored
        req_valid = 1; req_addr = ~a;
        cfg_cl = 2'(cl + 1); cfg_rcd = 2'(rcd + 1); cfg_rp = 2'(rp + 2);
      end
      step();
      if (q.size() == 0) req_valid = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) pipe[i] = 32'hBAD0_BAD0;
    repeat (3) step();          // R9: reset values
    rst_n = 1;
    repeat (2) step();          // R9: idle after reset
    fill({13'h0123, 9'h040}, 2, 1, 1, 0);   // start 0, CL2
    fill({13'h1FFF, 9'h0A7}, 3, 0, 0, 1);   // start 3, rp 0: done with last beat
    fill({13'h0555, 9'h1F6}, 3, 3, 3, 1);   // start 2, long waits
    fill({13'h0AAA, 9'h011}, 0, 2, 0, 0);   // R4: CL 0 acts as 1, back to back
    fill({13'h0001, 9'h1FF}, 1, 0, 2, 1);   // start 3 at top of column space
    repeat (4) step();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule